// File: doc/BRIEF.md
# Byte-Wide Slave Configuration Port

This block is the parallel slave port through which an external host loads configuration bytes into a programmable device and reads them back. The port runs on the configuration clock. The host selects it with an active-low chip select. An active-low direction strobe chooses the direction: low means the host writes, high means the device returns bytes. Written bytes pass to an internal sink over a valid/ready pair. Readback bytes are taken from an internal source over a valid/ready pair and held on a registered output bus.

The port paces the host with a BUSY line. When BUSY is high at a rising edge, the byte on the bus was not taken, and the host keeps it there until an edge where BUSY is low. The direction is latched while the chip select is high. If the strobe moves while the port is selected, the port raises an abort flag instead of turning around. The flag blocks all traffic until the host deselects the port.

Top module: `cfg_byte_port`

## Requirements
- R1: After reset, `abort` is 0, `dout` equals the parameter `DOUT_RESET` (default 0), and `busy` is 0 while `cs_n` is high.
- R2: At a rising edge with `cs_n` high, no byte goes to the sink (`sink_valid` low), no byte is taken from the source (`src_ready` low), `dout` holds its value and `busy` is 0.
- R3: The direction is the level of `wr_n` sampled at edges with `cs_n` high. 0 means write and 1 means readback. It stays fixed for as long as `cs_n` stays low.
- R4: In write direction with `cs_n` low and no abort, `din` is handed to the sink at each rising edge where `sink_ready` is 1. `busy` equals the inverse of `sink_ready` in the same cycle. Bytes reach the sink in host order, with none lost or repeated.
- R5: In readback direction with `cs_n` low and no abort, each rising edge with `src_valid` high takes one source byte. That byte appears on `dout` after that edge. While `src_valid` is low, `busy` is 1 and `dout` holds.
- R6: If `wr_n` differs from the latched direction while `cs_n` is low, `busy` is 1 in that cycle, no transfer happens, and `abort` reads 1 after the next rising edge.
- R7: Once `abort` is 1, it stays 1 while `cs_n` is low. During that time `busy` is 1 and no byte moves in either direction.
- R8: A rising edge with `cs_n` high clears `abort` to 0 after that edge, and the next selected transfer proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, rising-edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Direction strobe: 0 write, 1 readback |
| din | input | DATA_W | Host write data |
| busy | output | 1 | Byte not taken at this edge; host must hold |
| dout | output | DATA_W | Registered readback data |
| abort | output | 1 | Unexpected direction change seen |
| sink_valid | output | 1 | Write byte offered to the internal sink |
| sink_data | output | DATA_W | Write byte to the internal sink |
| sink_ready | input | 1 | Internal sink can take a byte |
| src_valid | input | 1 | Internal source has a readback byte |
| src_data | input | DATA_W | Readback byte from the internal source |
| src_ready | output | 1 | Port takes the source byte at this edge |

## Verification
`busy` and the sink/source handshakes are combinational in the present inputs, so they are due in the same cycle the inputs are driven. The bench checks them one time step after driving on the falling edge. `dout` and `abort` are registered and change at the rising edge that acts on the input. The bench samples them at the falling edge that follows, which is one cycle after the stimulus. The write sweep covers all 256 byte values under a stalling sink. The readback sweep compares each popped byte with an arithmetic sequence, and stalls leave `dout` unchanged.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
   // Direction encoding follows the strobe level.
   typedef enum logic {
      XFER_WRITE = 1'b0,
      XFER_READ  = 1'b1
   } xfer_dir_e;

   localparam int unsigned MAX_DATA_W = 64;
endpackage

// File: rtl/cfg_dir_guard.sv
module cfg_dir_guard
   import cfg_port_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cs_n,
   input  logic      wr_n,
   output xfer_dir_e dir,
   output logic      mismatch,
   output logic      abort_q,
   output logic      go
);
   xfer_dir_e dir_q;
   logic      armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= XFER_READ;
         abort_q <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         armed_q <= 1'b1;
         if (cs_n) begin
            dir_q   <= xfer_dir_e'(wr_n);
            abort_q <= 1'b0;
         end else if (mismatch) begin
            abort_q <= 1'b1;
         end
      end
   end

   always_comb begin
      dir      = dir_q;
      mismatch = !cs_n && (xfer_dir_e'(wr_n) != dir_q);
      go       = !cs_n && !abort_q && !mismatch;
   end

   // R6
   abort_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && !cs_n && !$past(cs_n) && (wr_n != $past(wr_n))) |=> abort_q);
   // R7
   abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_q && !cs_n) |=> abort_q);
   // R8
   abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> !abort_q);
   // R3
   dir_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |=> $stable(dir_q));
endmodule

// File: rtl/cfg_wr_path.sv
module cfg_wr_path #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              go,
   input  logic              dir_is_write,
   input  logic [DATA_W-1:0] din,
   input  logic              sink_ready,
   output logic              sink_valid,
   output logic [DATA_W-1:0] sink_data,
   output logic              stall
);
   always_comb begin
      sink_valid = go && dir_is_write;
      sink_data  = din;
      stall      = !sink_ready;
   end
endmodule

// File: rtl/cfg_rd_path.sv
module cfg_rd_path #(
   parameter int unsigned       DATA_W     = 8,
   parameter logic [DATA_W-1:0] DOUT_RESET = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              dir_is_read,
   input  logic              src_valid,
   input  logic [DATA_W-1:0] src_data,
   output logic              src_ready,
   output logic [DATA_W-1:0] dout,
   output logic              stall
);
   logic [DATA_W-1:0] dout_q;

   always_comb begin
      src_ready = go && dir_is_read && src_valid;
      stall     = !src_valid;
      dout      = dout_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         dout_q <= DOUT_RESET;
      else if (src_ready) dout_q <= src_data;
   end

   // R5
   rd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_ready |=> (dout_q == $past(src_data)));
   // R5
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !src_ready |=> $stable(dout_q));
endmodule

// File: rtl/cfg_byte_port.sv
module cfg_byte_port
   import cfg_port_pkg::*;
#(
   parameter int unsigned       DATA_W     = 8,
   parameter bit                RD_ENABLE  = 1'b1,
   parameter logic [DATA_W-1:0] DOUT_RESET = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic [DATA_W-1:0] din,
   output logic              busy,
   output logic [DATA_W-1:0] dout,
   output logic              abort,
   output logic              sink_valid,
   output logic [DATA_W-1:0] sink_data,
   input  logic              sink_ready,
   input  logic              src_valid,
   input  logic [DATA_W-1:0] src_data,
   output logic              src_ready
);
   initial begin
      param_width_chk: assert (DATA_W >= 1 && DATA_W <= MAX_DATA_W)
         else $error("DATA_W out of range");
   end

   xfer_dir_e dir;
   logic      mismatch;
   logic      abort_q;
   logic      go;
   logic      wr_stall;
   logic      rd_stall;
   logic      dir_stall;

   cfg_dir_guard u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n     (cs_n),
      .wr_n     (wr_n),
      .dir      (dir),
      .mismatch (mismatch),
      .abort_q  (abort_q),
      .go       (go)
   );

   cfg_wr_path #(.DATA_W(DATA_W)) u_wr (
      .go           (go),
      .dir_is_write (dir == XFER_WRITE),
      .din          (din),
      .sink_ready   (sink_ready),
      .sink_valid   (sink_valid),
      .sink_data    (sink_data),
      .stall        (wr_stall)
   );

   generate
      if (RD_ENABLE) begin : g_rd
         cfg_rd_path #(.DATA_W(DATA_W), .DOUT_RESET(DOUT_RESET)) u_rd (
            .clk         (clk),
            .rst_n       (rst_n),
            .go          (go),
            .dir_is_read (dir == XFER_READ),
            .src_valid   (src_valid),
            .src_data    (src_data),
            .src_ready   (src_ready),
            .dout        (dout),
            .stall       (rd_stall)
         );
      end else begin : g_no_rd
         logic unused_rd;
         always_comb begin
            src_ready = 1'b0;
            dout      = DOUT_RESET;
            rd_stall  = 1'b1;
            unused_rd = src_valid ^ (^src_data);
         end
      end
   endgenerate

   always_comb begin
      dir_stall = (dir == XFER_READ) ? rd_stall : wr_stall;
      busy      = !cs_n && (abort_q || mismatch || dir_stall);
      abort     = abort_q;
   end

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (!sink_valid && !src_ready && !busy));
   // R4
   wr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !wr_n && !sink_ready) |-> busy);
   // R7
   abort_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> (!sink_valid && !src_ready));
   // R4
   handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sink_valid && sink_ready) |-> !busy);
endmodule

// File: tb/cfg_byte_port_bench.sv
`timescale 1ns/1ps
module cfg_byte_port_bench;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cs_n = 1'b1;
   logic         wr_n = 1'b1;
   logic [W-1:0] din = '0;
   logic         busy;
   logic [W-1:0] dout;
   logic         abort;
   logic         sink_valid;
   logic [W-1:0] sink_data;
   logic         sink_ready = 1'b1;
   logic         src_valid = 1'b0;
   logic [W-1:0] src_data;
   logic         src_ready;

   int checks = 0;
   int errors = 0;
   int rx_n = 0;
   logic [W-1:0] rx [0:511];
   int src_idx = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cfg_byte_port u_cfg_byte_port (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .din(din),
      .busy(busy), .dout(dout), .abort(abort),
      .sink_valid(sink_valid), .sink_data(sink_data), .sink_ready(sink_ready),
      .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready)
   );

   function automatic logic [W-1:0] src_byte(int i);
      return W'((i * 37 + 5) & 8'hFF);
   endfunction

   assign src_data = src_byte(src_idx);

   always @(posedge clk) begin
      if (sink_valid && sink_ready) begin
         if (rx_n < 512) rx[rx_n] = sink_data;
         rx_n = rx_n + 1;
      end
      if (src_valid && src_ready) src_idx <= src_idx + 1;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         finish_run();
      end
   end

   initial begin
      int rx_before;
      logic [W-1:0] exp_dout;
      int pops;

      repeat (3) @(negedge clk);
      #1;
      check(abort == 1'b0, "R1 abort", abort, 0);
      check(dout == '0, "R1 dout", dout, 0);
      check(busy == 1'b0, "R1 busy", busy, 0);
      rst_n = 1'b1;

      // R2: deselected with write level and ready sink: nothing moves
      @(negedge clk);
      wr_n = 1'b0; din = 8'hA5; sink_ready = 1'b1; src_valid = 1'b1;
      rx_before = rx_n;
      repeat (4) begin
         @(negedge clk);
         #1;
         check(busy == 1'b0 && sink_valid == 1'b0 && src_ready == 1'b0,
               "R2 idle", {busy, sink_valid, src_ready}, 0);
      end
      check(rx_n == rx_before, "R2 no sink", rx_n, rx_before);
      check(src_idx == 0, "R2 no pop", src_idx, 0);
      check(dout == '0, "R2 dout hold", dout, 0);
      src_valid = 1'b0;

      // R4 / R3: write all 256 values, sink stalls every third cycle
      rx_before = rx_n;
      cs_n = 1'b0;
      for (int b = 0; b < 256; b++) begin
         bit taken;
         din = W'(b);
         taken = 1'b0;
         while (!taken) begin
            sink_ready = ((cycles % 3) != 2);
            #1;
            check(busy == !sink_ready, "R4 busy", busy, !sink_ready);
            taken = !busy;
            @(negedge clk);
         end
      end
      cs_n = 1'b1; sink_ready = 1'b1;
      check(rx_n - rx_before == 256, "R4 count", rx_n - rx_before, 256);
      for (int i = 0; i < 256; i++)
         if (rx[rx_before + i] != W'(i))
            check(1'b0, "R4 order", rx[rx_before + i], i);
      check(1'b1, "R4 order", 0, 0);

      // R5: readback with a stalling source
      @(negedge clk);
      wr_n = 1'b1;
      @(negedge clk);
      cs_n = 1'b0;
      exp_dout = '0;
      pops = 0;
      for (int c = 0; c < 96; c++) begin
         src_valid = ((c % 4) != 3);
         #1;
         check(busy == !src_valid, "R5 busy", busy, !src_valid);
         if (src_valid) begin exp_dout = src_byte(pops); pops++; end
         @(negedge clk);
         #1;
         check(dout == exp_dout, "R5 dout", dout, exp_dout);
      end
      src_valid = 1'b0;
      check(src_idx == pops, "R5 pops", src_idx, pops);

      // R6 / R7: toggle strobe while reading
      wr_n = 1'b0;
      #1;
      check(busy == 1'b1, "R6 busy same cycle", busy, 1);
      check(sink_valid == 1'b0, "R6 no write", sink_valid, 0);
      @(negedge clk);
      #1;
      check(abort == 1'b1, "R6 abort", abort, 1);
      wr_n = 1'b1; src_valid = 1'b1;
      repeat (3) begin
         #1;
         check(busy == 1'b1 && src_ready == 1'b0, "R7 blocked", {busy, src_ready}, 2);
         @(negedge clk);
         #1;
         check(abort == 1'b1, "R7 hold", abort, 1);
         check(dout == exp_dout, "R7 dout", dout, exp_dout);
      end
      src_valid = 1'b0;

      // R8: deselect clears, then write works
      cs_n = 1'b1; wr_n = 1'b0;
      @(negedge clk);
      #1;
      check(abort == 1'b0, "R8 clear", abort, 0);
      rx_before = rx_n;
      cs_n = 1'b0; din = 8'h3C; sink_ready = 1'b1;
      #1;
      check(busy == 1'b0, "R8 busy", busy, 0);
      @(negedge clk);
      cs_n = 1'b1;
      check(rx_n == rx_before + 1 && rx[rx_before] == 8'h3C, "R8 resume", rx[rx_before], 8'h3C);

      // R6 / R7 in write direction: abort blocks sink with ready high
      @(negedge clk);
      cs_n = 1'b0;
      @(negedge clk);
      wr_n = 1'b1;
      @(negedge clk);
      wr_n = 1'b0;
      rx_before = rx_n;
      #1;
      check(abort == 1'b1, "R6 write abort", abort, 1);
      check(busy == 1'b1, "R7 write busy", busy, 1);
      @(negedge clk);
      check(rx_n == rx_before, "R7 no write", rx_n, rx_before);
      cs_n = 1'b1;
      @(negedge clk);
      #1;
      check(abort == 1'b0, "R8 clear2", abort, 0);

      finish_run();
   end
endmodule